// File: doc/BRIEF.md
# Touch ADC Channel Scan Sequencer

This block is the SPI master for an eight-input serial converter of the kind used for resistive touch panels. One `start` pulse begins a scan. The block walks the enabled inputs from index 0 up to index 7. For each enabled input it issues a group of back-to-back conversion frames. The leading frames of a group are thrown away while the plates settle. The rest are summed and divided by their count, rounding up. The block then presents one 12-bit mean per enabled input on a result strobe. A single `scan_done` pulse closes the scan.

Each frame lasts 24 SCLK periods. The first eight periods carry a command byte on MOSI and the remaining sixteen bring the reading back on MISO. The converter is told to stay powered between frames of a group. Only the final frame of a group lets it power down. The skip and average counts are per input and come in as flat vectors, `CNT_W` bits per input. The SCLK half period is a fixed number of system clocks, so the default of 21 gives just under 3 MHz from a 125 MHz clock.

Top module: `adc_scan_seq`

## Requirements
- R1: SCLK idles low whenever `cs_n` is high. Each conversion frame has exactly 24 SCLK rising edges, with data sent MSB first. MOSI is set up before each rising edge and MISO is sampled on the rising edge (SPI mode 0).
- R2: The command byte of every frame has bit 7 = 1, bits 6:4 = the input index, bit 3 = 0 (12-bit conversion), bit 2 = the `SINGLE_ENDED` parameter (default 0) and bits 1:0 = power control.
- R3: Power bits 1:0 are 2'b01 on every frame of a group except the last, and 2'b00 on the last frame of the group.
- R4: A frame's sample is bits 14:3 of the 16-bit word received MSB first, which is the word shifted right by 3 and cut to 12 bits. A group has skip + average frames. The first skip samples are dropped, and the output is ceil(sum of the remaining samples / average).
- R5: Enabled inputs are scanned in ascending index order. Their results appear on consecutive `res_slot` values starting at 0, with no slot spent on a disabled input.
- R6: An average count of 0 on an enabled input behaves exactly like an average count of 1.
- R7: `cs_n` falls once, before the first frame of a scan, and stays low until after the last frame. MOSI is 0 during the 16 data periods of every frame.
- R8: `scan_done` is a one-cycle pulse that comes after the last `res_valid` of the scan. `start` is ignored while `busy` is high.
- R9: A scan with an all-zero enable mask produces `scan_done` with no result, no SCLK edge and no `cs_n` activity.
- R10: After reset, `cs_n` is 1, `sclk` is 0 and `busy`, `res_valid` and `scan_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one scan (sampled only while idle) |
| ch_en | input | 8 | Input enable mask, bit n enables input n |
| skip_cnt | input | 8*CNT_W | Settling frames to drop, input n at bits n*CNT_W +: CNT_W |
| avg_cnt | input | 8*CNT_W | Frames to average, same packing as skip_cnt |
| miso | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the converter |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | High from start until the scan ends |
| res_valid | output | 1 | One-cycle strobe marking a result |
| res_slot | output | 3 | Packed result slot of the current result |
| res_data | output | 12 | Rounded-up mean of the kept samples |
| scan_done | output | 1 | One-cycle end-of-scan pulse |

## Verification
A wrong frame or group counter shows at the pins within one frame. The slave sees a command byte with the wrong address or power bits, or a frame that is not 24 edges long. A wrong walk over the enable mask shows as a misordered or gapped slot or a missing or extra group, no later than the end of the scan. Faults in the accumulator or the divider only show in the value of `res_data`. The stimulus therefore uses samples whose kept sums are not multiples of the count, so that floor-versus-ceiling and off-by-one skip errors change the expected mean.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    localparam int NUM_CH     = 8;
    localparam int ADDR_W     = 3;
    localparam int CMD_W      = 8;
    localparam int DATA_BITS  = 16;
    localparam int FRAME_BITS = CMD_W + DATA_BITS;
    localparam int RES_W      = 12;
    localparam int PAD_BITS   = 3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PICK,
        S_LAUNCH,
        S_WAIT,
        S_EMIT,
        S_FINISH
    } seq_state_e;

    typedef struct packed {
        logic              strt;
        logic [ADDR_W-1:0] addr;
        logic              low_res;
        logic              single;
        logic [1:0]        pwr;
    } cmd_t;

    function automatic logic [CMD_W-1:0] build_cmd(
        input logic [ADDR_W-1:0] addr,
        input logic              keep_on,
        input logic              single
    );
        cmd_t c;
        c.strt    = 1'b1;
        c.addr    = addr;
        c.low_res = 1'b0;
        c.single  = single;
        c.pwr     = {1'b0, keep_on};
        return c;
    endfunction

    function automatic logic [RES_W-1:0] word_to_sample(input logic [DATA_BITS-1:0] w);
        return w[RES_W+PAD_BITS-1:PAD_BITS];
    endfunction

endpackage

// File: rtl/adc_frame_engine.sv
module adc_frame_engine
    import adc_scan_pkg::*;
#(
    parameter int HALF_PERIOD = 21
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 go,
    input  logic [CMD_W-1:0]     cmd,
    input  logic                 miso,
    output logic                 sclk,
    output logic                 mosi,
    output logic                 active,
    output logic                 done,
    output logic [DATA_BITS-1:0] word
);
    localparam int HC_W  = $clog2(HALF_PERIOD + 1);
    localparam int BIT_W = $clog2(FRAME_BITS);

    logic [HC_W-1:0]       hcnt;
    logic [BIT_W-1:0]      bitn;
    logic [FRAME_BITS-1:0] tx;
    logic [DATA_BITS-1:0]  rx;
    logic                  sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            hcnt   <= '0;
            bitn   <= '0;
            tx     <= '0;
            rx     <= '0;
            sclk_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (go) begin
                    active <= 1'b1;
                    tx     <= {cmd, {DATA_BITS{1'b0}}};
                    hcnt   <= '0;
                    bitn   <= '0;
                    sclk_q <= 1'b0;
                end
            end else if (hcnt == HC_W'(HALF_PERIOD - 1)) begin
                hcnt <= '0;
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                    rx     <= {rx[DATA_BITS-2:0], miso};
                end else begin
                    sclk_q <= 1'b0;
                    tx     <= {tx[FRAME_BITS-2:0], 1'b0};
                    if (bitn == BIT_W'(FRAME_BITS - 1)) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        bitn <= bitn + 1'b1;
                    end
                end
            end else begin
                hcnt <= hcnt + 1'b1;
            end
        end
    end

    assign sclk = sclk_q;
    assign mosi = active & tx[FRAME_BITS-1];
    assign word = rx;

    // R7: nothing but zeros leaves on MOSI once the command byte is out
    p_data_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (active && bitn >= BIT_W'(CMD_W)) |-> !mosi);

    // R1: a new frame is only launched into an idle engine
    p_go_idle_r1: assert property (@(posedge clk) disable iff (rst)
        go |-> !active);

    // R1: a frame ends with SCLK back at its idle level
    p_end_low_r1: assert property (@(posedge clk) disable iff (rst)
        done |-> !sclk_q);

endmodule

// File: rtl/adc_mean_accum.sv
module adc_mean_accum
    import adc_scan_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 add,
    input  logic [DATA_BITS-1:0] word,
    input  logic [CNT_W-1:0]     navg,
    output logic [RES_W-1:0]     mean
);
    localparam int ACC_W = RES_W + CNT_W;

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] den;
    logic [ACC_W-1:0] num;
    logic [ACC_W-1:0] quo;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc <= '0;
        end else if (add) begin
            acc <= acc + ACC_W'(word_to_sample(word));
        end
    end

    always_comb begin
        den  = ACC_W'(navg);
        num  = acc + den - ACC_W'(1);
        quo  = (den == '0) ? acc : (num / den);
        mean = quo[RES_W-1:0];
    end

    // R4: the sum moves only when a kept sample arrives or a group opens
    p_acc_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!clr && !add) |=> $stable(acc));

    // R4: a cleared accumulator reads zero
    p_acc_clear_r4: assert property (@(posedge clk) disable iff (rst)
        clr |=> (acc == '0));

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
    import adc_scan_pkg::*;
#(
    parameter int   CNT_W        = 4,
    parameter logic SINGLE_ENDED = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [NUM_CH-1:0]       ch_en,
    input  logic [NUM_CH*CNT_W-1:0] skip_flat,
    input  logic [NUM_CH*CNT_W-1:0] avg_flat,
    output logic                    fe_go,
    output logic [CMD_W-1:0]        fe_cmd,
    input  logic                    fe_done,
    output logic                    acc_clr,
    output logic                    acc_add,
    output logic [CNT_W-1:0]        acc_navg,
    input  logic [RES_W-1:0]        acc_mean,
    output logic                    cs_n,
    output logic                    busy,
    output logic                    res_valid,
    output logic [ADDR_W-1:0]       res_slot,
    output logic [RES_W-1:0]        res_data,
    output logic                    scan_done
);
    localparam int              TOT_W   = CNT_W + 1;
    localparam logic [ADDR_W-1:0] LAST_CH = ADDR_W'(NUM_CH - 1);

    seq_state_e        state;
    logic [ADDR_W-1:0] ch_idx;
    logic [ADDR_W-1:0] slot;
    logic [TOT_W-1:0]  frame_k;
    logic [TOT_W-1:0]  total;
    logic [CNT_W-1:0]  cur_skip;
    logic [CNT_W-1:0]  navg;
    logic              cs_low;
    logic [CMD_W-1:0]  sent_cmd;
    logic              valid_q;
    logic              done_q;
    logic [ADDR_W-1:0] slot_q;
    logic [RES_W-1:0]  data_q;

    logic [CNT_W-1:0]  sel_skip;
    logic [CNT_W-1:0]  sel_avg;
    logic [CNT_W-1:0]  sel_navg;
    logic              last_frame;

    always_comb begin
        sel_skip   = skip_flat[int'(ch_idx)*CNT_W +: CNT_W];
        sel_avg    = avg_flat[int'(ch_idx)*CNT_W +: CNT_W];
        sel_navg   = (sel_avg == '0) ? CNT_W'(1) : sel_avg;
        last_frame = (frame_k == total - TOT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            ch_idx   <= '0;
            slot     <= '0;
            frame_k  <= '0;
            total    <= '0;
            cur_skip <= '0;
            navg     <= CNT_W'(1);
            cs_low   <= 1'b0;
            sent_cmd <= '0;
            valid_q  <= 1'b0;
            done_q   <= 1'b0;
            slot_q   <= '0;
            data_q   <= '0;
        end else begin
            valid_q <= 1'b0;
            done_q  <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        ch_idx <= '0;
                        slot   <= '0;
                        state  <= S_PICK;
                    end
                end
                S_PICK: begin
                    if (ch_en[ch_idx]) begin
                        cur_skip <= sel_skip;
                        navg     <= sel_navg;
                        total    <= TOT_W'(sel_skip) + TOT_W'(sel_navg);
                        frame_k  <= '0;
                        state    <= S_LAUNCH;
                    end else if (ch_idx == LAST_CH) begin
                        state <= S_FINISH;
                    end else begin
                        ch_idx <= ch_idx + 1'b1;
                    end
                end
                S_LAUNCH: begin
                    cs_low   <= 1'b1;
                    sent_cmd <= fe_cmd;
                    state    <= S_WAIT;
                end
                S_WAIT: begin
                    if (fe_done) begin
                        if (last_frame) begin
                            state <= S_EMIT;
                        end else begin
                            frame_k <= frame_k + 1'b1;
                            state   <= S_LAUNCH;
                        end
                    end
                end
                S_EMIT: begin
                    valid_q <= 1'b1;
                    data_q  <= acc_mean;
                    slot_q  <= slot;
                    slot    <= slot + 1'b1;
                    if (ch_idx == LAST_CH) begin
                        state <= S_FINISH;
                    end else begin
                        ch_idx <= ch_idx + 1'b1;
                        state  <= S_PICK;
                    end
                end
                S_FINISH: begin
                    cs_low <= 1'b0;
                    done_q <= 1'b1;
                    state  <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign fe_go     = (state == S_LAUNCH);
    assign fe_cmd    = build_cmd(ch_idx, !last_frame, SINGLE_ENDED);
    assign acc_clr   = (state == S_PICK) && ch_en[ch_idx];
    assign acc_add   = (state == S_WAIT) && fe_done && (frame_k >= TOT_W'(cur_skip));
    assign acc_navg  = navg;
    assign cs_n      = !cs_low;
    assign busy      = (state != S_IDLE);
    assign res_valid = valid_q;
    assign res_slot  = slot_q;
    assign res_data  = data_q;
    assign scan_done = done_q;

    // R3: the frame that closes a group was sent with both power bits clear
    p_last_pwrdn_r3: assert property (@(posedge clk) disable iff (rst)
        (state == S_WAIT && fe_done && last_frame) |-> (sent_cmd[1:0] == 2'b00));

    // R3: frames before the last of the group keep the converter on
    p_keep_on_r3: assert property (@(posedge clk) disable iff (rst)
        (state == S_WAIT && fe_done && !last_frame) |-> (sent_cmd[1:0] == 2'b01));

    // R2: every command carries the start bit and asks for 12-bit mode
    p_cmd_frame_r2: assert property (@(posedge clk) disable iff (rst)
        (state == S_WAIT) |-> (sent_cmd[7] && !sent_cmd[3] && sent_cmd[6:4] == ch_idx));

    // R6: the divisor seen by the accumulator is never zero
    p_navg_nz_r6: assert property (@(posedge clk) disable iff (rst)
        (state == S_EMIT) |-> (navg != '0));

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int   CNT_W        = 4,
    parameter int   HALF_PERIOD  = 21,
    parameter logic SINGLE_ENDED = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [NUM_CH-1:0]       ch_en,
    input  logic [NUM_CH*CNT_W-1:0] skip_cnt,
    input  logic [NUM_CH*CNT_W-1:0] avg_cnt,
    input  logic                    miso,
    output logic                    sclk,
    output logic                    mosi,
    output logic                    cs_n,
    output logic                    busy,
    output logic                    res_valid,
    output logic [ADDR_W-1:0]       res_slot,
    output logic [RES_W-1:0]        res_data,
    output logic                    scan_done
);
    logic                 fe_go;
    logic [CMD_W-1:0]     fe_cmd;
    logic                 fe_done;
    logic                 fe_active;
    logic [DATA_BITS-1:0] fe_word;
    logic                 acc_clr;
    logic                 acc_add;
    logic [CNT_W-1:0]     acc_navg;
    logic [RES_W-1:0]     acc_mean;

    adc_scan_ctrl #(
        .CNT_W        (CNT_W),
        .SINGLE_ENDED (SINGLE_ENDED)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .ch_en     (ch_en),
        .skip_flat (skip_cnt),
        .avg_flat  (avg_cnt),
        .fe_go     (fe_go),
        .fe_cmd    (fe_cmd),
        .fe_done   (fe_done),
        .acc_clr   (acc_clr),
        .acc_add   (acc_add),
        .acc_navg  (acc_navg),
        .acc_mean  (acc_mean),
        .cs_n      (cs_n),
        .busy      (busy),
        .res_valid (res_valid),
        .res_slot  (res_slot),
        .res_data  (res_data),
        .scan_done (scan_done)
    );

    adc_frame_engine #(
        .HALF_PERIOD (HALF_PERIOD)
    ) u_frame (
        .clk    (clk),
        .rst    (rst),
        .go     (fe_go),
        .cmd    (fe_cmd),
        .miso   (miso),
        .sclk   (sclk),
        .mosi   (mosi),
        .active (fe_active),
        .done   (fe_done),
        .word   (fe_word)
    );

    adc_mean_accum #(
        .CNT_W (CNT_W)
    ) u_accum (
        .clk  (clk),
        .rst  (rst),
        .clr  (acc_clr),
        .add  (acc_add),
        .word (fe_word),
        .navg (acc_navg),
        .mean (acc_mean)
    );

    // R1: no clocking toward the converter while it is deselected
    p_sclk_idle_r1: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    // R7: a frame only runs with the converter selected
    p_frame_sel_r7: assert property (@(posedge clk) disable iff (rst)
        fe_active |-> !cs_n);

    // R7: chip select is only held during a scan
    p_cs_busy_r7: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> busy);

    // R8: end-of-scan is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        scan_done |=> !scan_done);

    // R5: results only appear inside a scan
    p_result_in_scan_r5: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> busy);

endmodule

// File: tb/adc_scan_seq_tb.sv
module adc_scan_seq_tb;
    localparam int CNT_W = 4;
    localparam int HALF  = 3;
    localparam int MAXF  = 256;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               start = 1'b0;
    logic [7:0]         ch_en = '0;
    logic [8*CNT_W-1:0] skip_cnt = '0;
    logic [8*CNT_W-1:0] avg_cnt = '0;
    logic               miso = 1'b0;
    logic               sclk, mosi, cs_n, busy, res_valid, scan_done;
    logic [2:0]         res_slot;
    logic [11:0]        res_data;

    always #4 clk = ~clk;

    adc_scan_seq #(
        .CNT_W        (CNT_W),
        .HALF_PERIOD  (HALF),
        .SINGLE_ENDED (1'b0)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .ch_en     (ch_en),
        .skip_cnt  (skip_cnt),
        .avg_cnt   (avg_cnt),
        .miso      (miso),
        .sclk      (sclk),
        .mosi      (mosi),
        .cs_n      (cs_n),
        .busy      (busy),
        .res_valid (res_valid),
        .res_slot  (res_slot),
        .res_data  (res_data),
        .scan_done (scan_done)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // converter model state
    logic [15:0] word_tab [MAXF];
    logic [7:0]  got_cmd  [MAXF];
    logic [7:0]  exp_cmd  [MAXF];
    logic [11:0] exp_res  [8];
    logic [11:0] got_res  [8];
    int          got_slot [8];
    logic [7:0]  cmdsh;
    int bitpos, frame_no, rises, mosi_bad, sclk_bad, cs_falls, n_res, n_done;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [11:0] gen(input int ch, input int k);
        return 12'((ch * 517 + k * 1231 + 89) % 4096);
    endfunction

    always @(negedge cs_n) cs_falls++;

    always @(posedge sclk) begin
        if (!cs_n) begin
            rises++;
            if (bitpos < 8) begin
                cmdsh = {cmdsh[6:0], mosi};
                if (bitpos == 7 && frame_no < MAXF) got_cmd[frame_no] = cmdsh;
            end else if (mosi) begin
                mosi_bad++;
            end
            bitpos++;
            if (bitpos == 24) begin
                bitpos = 0;
                frame_no++;
            end
        end
    end

    always @(negedge sclk) begin
        if (!cs_n) begin
            if (bitpos >= 8 && frame_no < MAXF) miso = word_tab[frame_no][23 - bitpos];
            else miso = 1'b0;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (res_valid) begin
                if (n_res < 8) begin
                    got_res[n_res]  = res_data;
                    got_slot[n_res] = int'(res_slot);
                end
                n_res++;
            end
            if (scan_done) n_done++;
            if (cs_n && sclk) sclk_bad++;
        end
    end

    task automatic run_scan(input string name, input logic [7:0] mask,
                            input int sk[8], input int av[8], input bit poke);
        int nexp = 0;
        int nr = 0;
        int t = 0;
        for (int c = 0; c < 8; c++) begin
            skip_cnt[c*CNT_W +: CNT_W] = CNT_W'(sk[c]);
            avg_cnt[c*CNT_W +: CNT_W]  = CNT_W'(av[c]);
            if (mask[c]) begin
                int na = (av[c] == 0) ? 1 : av[c];
                int tot = sk[c] + na;
                int sum = 0;
                for (int k = 0; k < tot; k++) begin
                    logic [11:0] v = gen(c, k);
                    word_tab[nexp] = {1'b0, v, 3'b101};
                    exp_cmd[nexp]  = 8'h80 | 8'(c << 4) | ((k == tot - 1) ? 8'h00 : 8'h01);
                    if (k >= sk[c]) sum += int'(v);
                    nexp++;
                end
                exp_res[nr] = 12'((sum + na - 1) / na);
                nr++;
            end
        end
        ch_en = mask;
        bitpos = 0; frame_no = 0; rises = 0; mosi_bad = 0; sclk_bad = 0;
        cs_falls = 0; n_res = 0; n_done = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (poke) begin
            repeat (50) @(negedge clk);
            check(busy == 1'b1, "R8", {name, " busy during scan"}, int'(busy), 1);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        while (n_done == 0 && t < 100000) begin
            @(negedge clk);
            t++;
        end
        check(t < 100000, "R8", {name, " scan_done arrives"}, t, 0);
        repeat (nexp == 0 ? 20 : 300) @(negedge clk);
        check(n_done == 1, "R8", {name, " single scan_done"}, n_done, 1);
        check(busy == 1'b0, "R8", {name, " idle after scan"}, int'(busy), 0);
        check(frame_no == nexp, "R1", {name, " frame count"}, frame_no, nexp);
        check(bitpos == 0 && rises == nexp * 24, "R1", {name, " 24 edges per frame"},
              rises, nexp * 24);
        check(sclk_bad == 0, "R1", {name, " sclk low while deselected"}, sclk_bad, 0);
        check(mosi_bad == 0, "R7", {name, " mosi low in data bits"}, mosi_bad, 0);
        check(cs_falls == (nexp > 0 ? 1 : 0), "R7/R9", {name, " cs_n falls once"},
              cs_falls, nexp > 0 ? 1 : 0);
        check(cs_n == 1'b1, "R7", {name, " cs_n high after scan"}, int'(cs_n), 1);
        for (int f = 0; f < nexp && f < MAXF; f++)
            check(got_cmd[f] == exp_cmd[f], "R2/R3", $sformatf("%s cmd frame %0d", name, f),
                  int'(got_cmd[f]), int'(exp_cmd[f]));
        check(n_res == nr, "R5", {name, " result count"}, n_res, nr);
        for (int r = 0; r < nr && r < n_res; r++) begin
            check(got_slot[r] == r, "R5", $sformatf("%s slot %0d", name, r), got_slot[r], r);
            check(got_res[r] == exp_res[r], "R4", $sformatf("%s mean %0d", name, r),
                  int'(got_res[r]), int'(exp_res[r]));
        end
    endtask

    task automatic t_reset();
        check(cs_n == 1'b1, "R10", "reset cs_n", int'(cs_n), 1);
        check(sclk == 1'b0, "R10", "reset sclk", int'(sclk), 0);
        check(busy == 1'b0, "R10", "reset busy", int'(busy), 0);
        check(res_valid == 1'b0 && scan_done == 1'b0, "R10", "reset strobes",
              int'(res_valid) + int'(scan_done), 0);
    endtask

    task automatic t_single();
        run_scan("single", 8'b0010_0000, '{0,0,0,0,0,2,0,0}, '{0,0,0,0,0,4,0,0}, 1'b0);
    endtask

    task automatic t_multi();
        run_scan("multi", 8'b1010_0110, '{0,1,0,0,0,2,0,1}, '{0,2,3,0,0,2,0,1}, 1'b0);
    endtask

    task automatic t_avg_zero();
        // R6: avg 0 behaves as avg 1
        run_scan("avg0", 8'b0000_1001, '{0,0,0,1,0,0,0,0}, '{0,0,0,0,0,0,0,0}, 1'b0);
    endtask

    task automatic t_empty();
        // R9: empty mask
        run_scan("empty", 8'h00, '{1,1,1,1,1,1,1,1}, '{1,1,1,1,1,1,1,1}, 1'b0);
    endtask

    task automatic t_all_busy();
        // R8: start re-pulsed mid-scan is ignored
        run_scan("all", 8'hFF, '{0,0,0,0,0,0,0,3}, '{1,1,1,1,1,1,1,2}, 1'b1);
    endtask

    task automatic t_max();
        run_scan("max", 8'b0100_0000, '{0,0,0,0,0,0,15,0}, '{0,0,0,0,0,0,15,0}, 1'b0);
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst = 1'b0;
        repeat (3) @(negedge clk);
        t_single();
        t_multi();
        t_avg_zero();
        t_empty();
        t_all_busy();
        t_max();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule